// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches CPU write cycles aimed at an on-chip flash and picks out the keyed command sequences that start the flash controller's automatic algorithm. Every multi-write command opens with a two-write unlock key at two fixed addresses. The third write, at the first key address, picks the command. The block recognises three commands: a return to read mode, a single-word program, and a six-write chip erase. Any write that breaks the expected pattern drops the partial sequence. That write is then judged again as a possible opening step.

When a command is accepted, the block issues a one-clock start pulse. A program start also latches the target address and data for the programming engine. A read/reset command produces a one-clock acknowledge. After a program or erase start the block stays busy and ignores every write until the engine raises its done input. The engine itself, its pulse timing, verify loops and status reporting all sit outside this block.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous active-high reset clears `busy`, all three pulse outputs and `prog_addr`/`prog_data`, and discards any partial sequence, so that a later command byte alone starts nothing.
- R2: Outside a sequence, a single write with data 0xF0 to any address gives `rd_mode_ack` high for exactly the one cycle after that write's clock edge.
- R3: The writes 0xAA@0xFAAA, 0x55@0xF554 and 0xF0@0xFAAA give `rd_mode_ack` one cycle after the third write, and a following non-write cycle has no effect.
- R4: The writes 0xAA@0xFAAA, 0x55@0xF554 and 0xA0@0xFAAA, followed by one write of any data to any address, give `prog_start` one cycle after that fourth write, with `busy` high from the same cycle.
- R5: The six writes 0xAA@0xFAAA, 0x55@0xF554, 0x80@0xFAAA, 0xAA@0xFAAA, 0x55@0xF554 and 0x10@0xFAAA give `erase_start` and `busy` one cycle after the sixth write. A sixth write with a wrong address or wrong data starts nothing.
- R6: A write that does not match the next expected step abandons the sequence. That write is then taken as a first step: 0xAA@0xFAAA opens a new unlock, data 0xF0 gives `rd_mode_ack`, and anything else leaves the block idle. A third-step byte other than 0xF0, 0xA0 or 0x80 starts nothing.
- R7: Cycles with `bus_wr` low in the middle of a sequence neither advance nor reset it.
- R8: While `busy` is high, writes cause no pulse and change no state. A high `op_done` clears `busy` on the next cycle, and `op_done` outside busy has no effect.
- R9: Each start pulse lasts one cycle. `prog_addr` and `prog_data` hold the fourth-write address and data from the `prog_start` cycle until the next program start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus write data |
| op_done | input | 1 | Program or erase engine finished |
| prog_start | output | 1 | One-cycle program launch pulse |
| prog_addr | output | 16 | Latched program address |
| prog_data | output | 8 | Latched program data |
| erase_start | output | 1 | One-cycle chip erase launch pulse |
| rd_mode_ack | output | 1 | One-cycle read/reset acknowledge |
| busy | output | 1 | Program or erase in progress |

## Verification
The bench aims at the restart rule. A write that breaks the key is replayed as an opening step: a design that simply drops it misses the unlock that follows, and a design that keeps the partial state lets a stray byte launch programming. A sixth erase write at the wrong address and an illegal third-step byte are both applied, so a decoder that checks only data, or treats every unknown byte as erase, shows a false start. Idle gaps inside sequences catch a design that advances or resets on non-write cycles. Writes during busy, including 0xF0 and 0xAA@0xFAAA, catch a design that keeps decoding while the engine runs. A reset in mid-sequence catches a design that leaves a stale partial state.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  parameter int FCS_AW = 16;
  parameter int FCS_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3, ST_BUSY
  } seq_st_t;

  // decoded facts about the current bus write
  typedef struct packed {
    logic open_key;  // first unlock write seen
    logic second_key;// second unlock write seen
    logic at_cmd;    // address is the command address
    logic is_rst;    // read/reset code
    logic is_prog;   // program code
    logic is_era;    // erase preamble code
    logic is_go;     // erase confirm code
  } key_hits_t;

  function automatic logic wr_hit(input logic [FCS_AW-1:0] a, input logic [FCS_DW-1:0] d,
                                  input logic [FCS_AW-1:0] ka, input logic [FCS_DW-1:0] kd);
    return (a == ka) && (d == kd);
  endfunction
endpackage

// File: rtl/fcs_key_match.sv
module fcs_key_match
  import fcs_pkg::*;
#(
  parameter int AW = FCS_AW,
  parameter int DW = FCS_DW,
  parameter logic [AW-1:0] ADDR_CMD = 16'hFAAA,
  parameter logic [AW-1:0] ADDR_ALT = 16'hF554,
  parameter logic [DW-1:0] KEY_OPEN = 8'hAA,
  parameter logic [DW-1:0] KEY_NEXT = 8'h55,
  parameter logic [DW-1:0] CODE_RST = 8'hF0,
  parameter logic [DW-1:0] CODE_PRG = 8'hA0,
  parameter logic [DW-1:0] CODE_ERA = 8'h80,
  parameter logic [DW-1:0] CODE_GO  = 8'h10
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output key_hits_t     hits
);
  always_comb begin
    hits.open_key   = wr_hit(addr, data, ADDR_CMD, KEY_OPEN);
    hits.second_key = wr_hit(addr, data, ADDR_ALT, KEY_NEXT);
    hits.at_cmd     = (addr == ADDR_CMD);
    hits.is_rst     = (data == CODE_RST);
    hits.is_prog    = (data == CODE_PRG);
    hits.is_era     = (data == CODE_ERA);
    hits.is_go      = (data == CODE_GO);
  end
endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
  import fcs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  logic      done,
  input  key_hits_t hits,
  output logic      ev_prog,
  output logic      ev_erase,
  output logic      ev_rdack,
  output logic      seq_abort,
  output logic      pls_prog,
  output logic      pls_erase,
  output logic      pls_rdack,
  output logic      in_busy
);
  seq_st_t st, nxt;
  seq_st_t rs_nxt;
  logic    rs_ack;

  // how a write would be taken if it were the opening step
  always_comb begin
    rs_nxt = hits.open_key ? ST_KEY1 : ST_IDLE;
    rs_ack = !hits.open_key && hits.is_rst;
  end

  always_comb begin
    nxt = st; ev_prog = 1'b0; ev_erase = 1'b0; ev_rdack = 1'b0; seq_abort = 1'b0;
    case (st)
      ST_IDLE: if (wr) begin nxt = rs_nxt; ev_rdack = rs_ack; end
      ST_KEY1, ST_ERA2: if (wr) begin
        if (hits.second_key) nxt = (st == ST_KEY1) ? ST_KEY2 : ST_ERA3;
        else begin seq_abort = 1'b1; nxt = rs_nxt; ev_rdack = rs_ack; end
      end
      ST_KEY2: if (wr) begin
        if (hits.at_cmd && hits.is_rst)       begin nxt = ST_IDLE; ev_rdack = 1'b1; end
        else if (hits.at_cmd && hits.is_prog) nxt = ST_PROG;
        else if (hits.at_cmd && hits.is_era)  nxt = ST_ERA1;
        else begin seq_abort = 1'b1; nxt = rs_nxt; ev_rdack = rs_ack; end
      end
      ST_PROG: if (wr) begin nxt = ST_BUSY; ev_prog = 1'b1; end
      ST_ERA1: if (wr) begin
        if (hits.open_key) nxt = ST_ERA2;
        else begin seq_abort = 1'b1; nxt = rs_nxt; ev_rdack = rs_ack; end
      end
      ST_ERA3: if (wr) begin
        if (hits.at_cmd && hits.is_go) begin nxt = ST_BUSY; ev_erase = 1'b1; end
        else begin seq_abort = 1'b1; nxt = rs_nxt; ev_rdack = rs_ack; end
      end
      ST_BUSY: if (done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      pls_prog <= 1'b0; pls_erase <= 1'b0; pls_rdack <= 1'b0;
    end else begin
      st <= nxt;
      pls_prog <= ev_prog; pls_erase <= ev_erase; pls_rdack <= ev_rdack;
    end
  end

  assign in_busy = (st == ST_BUSY);
endmodule

// File: rtl/fcs_prog_latch.sv
module fcs_prog_latch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] q_addr,
  output logic [DW-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr <= '0;
      q_data <= '0;
    end else if (load) begin
      q_addr <= addr;
      q_data <= data;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW = FCS_AW,
  parameter int DW = FCS_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          op_done,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          erase_start,
  output logic          rd_mode_ack,
  output logic          busy
);
  key_hits_t hits;
  logic ev_prog, ev_erase, ev_rdack, seq_abort;

  fcs_key_match #(.AW(AW), .DW(DW)) u_match (
    .addr(bus_addr), .data(bus_data), .hits(hits)
  );

  fcs_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .wr(bus_wr), .done(op_done), .hits(hits),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_rdack(ev_rdack), .seq_abort(seq_abort),
    .pls_prog(prog_start), .pls_erase(erase_start), .pls_rdack(rd_mode_ack),
    .in_busy(busy)
  );

  fcs_prog_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk(clk), .rst(rst), .load(ev_prog), .addr(bus_addr), .data(bus_data),
    .q_addr(prog_addr), .q_data(prog_data)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          op_done,
  input logic          prog_start,
  input logic          erase_start,
  input logic          rd_mode_ack,
  input logic          busy,
  input logic [AW-1:0] prog_addr,
  input logic [DW-1:0] prog_data,
  input logic          ev_prog,
  input logic          ev_erase,
  input logic          seq_abort
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !busy && !prog_start && !erase_start && !rd_mode_ack);

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({prog_start, erase_start, rd_mode_ack}) <= 1);

  p_prog_single_r9: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (prog_start || erase_start) |-> busy);

  p_prog_event_r4: assert property (@(posedge clk) disable iff (rst)
    ev_prog |=> prog_start);

  p_erase_event_r5: assert property (@(posedge clk) disable iff (rst)
    ev_erase |=> erase_start);

  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    seq_abort |=> !prog_start && !erase_start);

  p_no_write_no_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && !busy) |=> !prog_start && !erase_start && !rd_mode_ack);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> busy);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done) |=> !busy);

  p_busy_silent_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !prog_start && !erase_start && !rd_mode_ack);

  p_latch_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !prog_start && !erase_start) |-> $stable(prog_addr) && $stable(prog_data));
endmodule

bind flash_cmd_seq fcs_checker #(.AW(AW), .DW(DW)) i_fcs_checker (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .op_done(op_done),
  .prog_start(prog_start), .erase_start(erase_start), .rd_mode_ack(rd_mode_ack),
  .busy(busy), .prog_addr(prog_addr), .prog_data(prog_data),
  .ev_prog(ev_prog), .ev_erase(ev_erase), .seq_abort(seq_abort)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;
  logic clk = 1'b0;
  logic rst, bus_wr, op_done;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic prog_start, erase_start, rd_mode_ack, busy;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
    .op_done(op_done), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_start(erase_start), .rd_mode_ack(rd_mode_ack),
    .busy(busy)
  );

  // {req, wr, addr, data, done, exp {prog, erase, ack, busy}}
  localparam int NV = 60;
  localparam logic [33:0] VEC [NV] = '{
    {4'd2,1'b1,16'h1234,8'hF0,1'b0,4'b0010}, // R2 lone reset code
    {4'd7,1'b0,16'h0000,8'h00,1'b0,4'b0000}, // R7 idle
    {4'd3,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R3
    {4'd3,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd3,1'b1,16'hFAAA,8'hF0,1'b0,4'b0010},
    {4'd3,1'b0,16'hFAAA,8'h00,1'b0,4'b0000}, // R3 read cycle after
    {4'd4,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R4
    {4'd4,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd4,1'b1,16'hFAAA,8'hA0,1'b0,4'b0000},
    {4'd4,1'b1,16'h1357,8'h5A,1'b0,4'b1001},
    {4'd8,1'b0,16'h0000,8'h00,1'b0,4'b0001}, // R8 busy holds
    {4'd8,1'b1,16'hFAAA,8'hAA,1'b0,4'b0001},
    {4'd8,1'b1,16'h0000,8'hF0,1'b0,4'b0001},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000}, // R8 done while idle
    {4'd5,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R5
    {4'd5,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'h80,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000},
    {4'd5,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'h10,1'b0,4'b0101},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000},
    {4'd7,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R7 gaps
    {4'd7,1'b0,16'h0000,8'h00,1'b0,4'b0000},
    {4'd7,1'b0,16'hFAAA,8'hF0,1'b0,4'b0000},
    {4'd7,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd7,1'b0,16'h0000,8'h00,1'b0,4'b0000},
    {4'd7,1'b1,16'hFAAA,8'hA0,1'b0,4'b0000},
    {4'd7,1'b0,16'h0000,8'h00,1'b0,4'b0000},
    {4'd7,1'b1,16'h0100,8'h33,1'b0,4'b1001},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R6 wrong address
    {4'd6,1'b1,16'hFAAA,8'h55,1'b0,4'b0000},
    {4'd6,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'hA0,1'b0,4'b0000},
    {4'd6,1'b1,16'h2222,8'h44,1'b0,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R6 repeat opens again
    {4'd6,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000},
    {4'd6,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'hA0,1'b0,4'b0000},
    {4'd6,1'b1,16'h2000,8'h77,1'b0,4'b1001},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R6 reset code breaks key
    {4'd6,1'b1,16'hF554,8'hF0,1'b0,4'b0010},
    {4'd6,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R6 illegal command
    {4'd6,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd6,1'b1,16'hFAAA,8'h90,1'b0,4'b0000},
    {4'd6,1'b1,16'h3000,8'h22,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R5 bad sixth address
    {4'd5,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'h80,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000},
    {4'd5,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd5,1'b1,16'hF554,8'h10,1'b0,4'b0000},
    {4'd5,1'b1,16'hFAAA,8'h10,1'b0,4'b0000},
    {4'd4,1'b1,16'hFAAA,8'hAA,1'b0,4'b0000}, // R4 data word equal to reset code
    {4'd4,1'b1,16'hF554,8'h55,1'b0,4'b0000},
    {4'd4,1'b1,16'hFAAA,8'hA0,1'b0,4'b0000},
    {4'd4,1'b1,16'hFAAA,8'hF0,1'b0,4'b1001},
    {4'd8,1'b0,16'h0000,8'h00,1'b1,4'b0000}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [15:0] a, input logic [7:0] d, input logic dn);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_data = d; op_done = dn;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] outs();
    return {prog_start, erase_start, rd_mode_ack, busy};
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_data = '0; op_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outputs in reset", {28'd0, outs()}, 32'd0);
    chk("R1", "latch in reset", {8'd0, prog_addr, prog_data}, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][29], VEC[i][28:13], VEC[i][12:5], VEC[i][4]);
      chk($sformatf("R%0d", VEC[i][33:30]), $sformatf("vector %0d", i),
          {28'd0, outs()}, {28'd0, VEC[i][3:0]});
    end

    // R9: latched address/data and their hold through busy
    cyc(1'b1, 16'hFAAA, 8'hAA, 1'b0);
    cyc(1'b1, 16'hF554, 8'h55, 1'b0);
    cyc(1'b1, 16'hFAAA, 8'hA0, 1'b0);
    cyc(1'b1, 16'hBEEF, 8'hC3, 1'b0);
    chk("R9", "prog_addr at start", {16'd0, prog_addr}, 32'hBEEF);
    chk("R9", "prog_data at start", {24'd0, prog_data}, 32'hC3);
    cyc(1'b1, 16'h1111, 8'hEE, 1'b0);
    chk("R9", "pulse width", {31'd0, prog_start}, 32'd0);
    chk("R9", "prog_addr held", {16'd0, prog_addr}, 32'hBEEF);
    chk("R9", "prog_data held", {24'd0, prog_data}, 32'hC3);
    cyc(1'b0, 16'h0000, 8'h00, 1'b1);
    chk("R9", "prog_addr after done", {16'd0, prog_addr}, 32'hBEEF);

    // R1: reset in mid-sequence discards the partial key
    cyc(1'b1, 16'hFAAA, 8'hAA, 1'b0);
    cyc(1'b1, 16'hF554, 8'h55, 1'b0);
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0; @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    chk("R1", "latch cleared", {8'd0, prog_addr, prog_data}, 32'd0);
    cyc(1'b1, 16'hFAAA, 8'hA0, 1'b0);
    cyc(1'b1, 16'h4444, 8'h11, 1'b0);
    chk("R1", "no start after reset", {28'd0, outs()}, 32'd0);

    // R1: reset while busy
    cyc(1'b1, 16'hFAAA, 8'hAA, 1'b0);
    cyc(1'b1, 16'hF554, 8'h55, 1'b0);
    cyc(1'b1, 16'hFAAA, 8'hA0, 1'b0);
    cyc(1'b1, 16'h0F0F, 8'h3C, 1'b0);
    chk("R4", "start before reset", {28'd0, outs()}, 32'h9);
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0; @(posedge clk); #1;
    chk("R1", "busy cleared by reset", {28'd0, outs()}, 32'd0);
    @(negedge clk); rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule